// File: doc/BRIEF.md
# Paravirtual I/O Transport Register File

This block is the memory-mapped register front end of a paravirtual I/O device. A host processor reaches it through a 512-byte window on a simple single-cycle register bus. Through it, software identifies the device and negotiates feature words one 32-bit slice at a time. It also sets a guest page size, selects and sets up each virtual queue (size, alignment, page frame number), rings queue doorbells, reads and acknowledges interrupt causes, and drives the device status byte. Offsets from 0x100 to 0x1FF are not decoded here. They go straight to a device-specific configuration port.

A backend device sits behind the block and signals whether it is attached. It receives a strobe whenever a queue's setup changes, a doorbell strobe carrying the queue index, and a one-cycle device reset pulse. When no backend is attached, the block still answers the three identification registers, so a probe does not fail. Every other read returns zero and every write is dropped.

The guest page size is turned into a shift amount. That shift scales page frame numbers into queue base addresses and back.

Top module: `pvio_regfile`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x74726976, of 0x04 returns 1 and of 0x0C returns the VENDOR_ID parameter, whether or not a backend is present. A 4-byte read of 0x08 returns the device_id input while a backend is present.
- R2: While backend_present is 0, every read other than the three of R1 returns 0, including config-window reads. Every write is dropped: no register changes and no strobe or config access is produced.
- R3: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = invalid. Below 0x100, any access that is not size 2 reads 0 and writes have no effect.
- R4: For an access at 0x100..0x1FF of size 0, 1 or 2 with a backend present, the block asserts cfg_valid in the same cycle. It drives cfg_addr = address minus 0x100, cfg_size, cfg_write and cfg_wdata, and the read response carries cfg_rdata.
- R5: A read of 0x10 returns host_features while the select register at 0x14 holds 0, and returns 0 for any other select value.
- R6: A write to 0x20 updates guest_features only while the select register at 0x24 holds 0.
- R7: A write to 0x28 sets the page shift to the number of trailing zeros of the value, or to 0 when the value is 0. A nonzero write to 0x40 sets the selected queue's base to value << shift. A read of 0x40 returns base >> shift.
- R8: Writing 0 to 0x40, or writing a value whose low byte is 0 to 0x70, pulses dev_reset for one cycle. The device reset clears status, interrupt status, queue select, guest features and every queue base, and leaves the page shift and the two select registers unchanged.
- R9: Writes to 0x30 (queue select) and 0x50 (notify) are ignored when the value is not below NQ. An accepted notify produces a one-cycle notify_valid with notify_idx equal to the value.
- R10: Interrupt status bits are set from isr_set and read at 0x60. A write to 0x64 clears the bits set in the written value. irq is high exactly while the interrupt status is nonzero.
- R11: A write to 0x70 stores the low 8 bits as the status, which reads back at 0x70.
- R12: A write to 0x38 with a value above QMAX is ignored. Each accepted write to 0x38, to 0x3C, or of a nonzero value to 0x40 gives a one-cycle qset_valid carrying the selected queue's index, size, alignment and base after the write.
- R13: A read of 0x34 returns QMAX. Reads of write-only registers (0x14, 0x20, 0x24, 0x28, 0x30, 0x38, 0x3C, 0x50, 0x64) and of unmapped offsets return 0.
- R14: After reset, irq, dev_reset, notify_valid, qset_valid and rsp_valid are 0, guest_features is 0, and the page shift and both select registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always 1: every request completes in one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset in the window |
| req_size | input | 2 | Access size code (see R3) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| backend_present | input | 1 | A backend device is attached |
| device_id | input | 32 | Backend device type |
| host_features | input | 32 | Backend feature word |
| isr_set | input | ISR_W | Interrupt cause bits to set |
| cfg_valid | output | 1 | Config window access |
| cfg_write | output | 1 | Config access is a write |
| cfg_addr | output | 8 | Offset inside the config window |
| cfg_size | output | 2 | Config access size code |
| cfg_wdata | output | 32 | Config write data |
| cfg_rdata | input | 32 | Config read data, same cycle |
| guest_features | output | 32 | Accepted guest feature word |
| qset_valid | output | 1 | Queue setup changed |
| qset_idx | output | QI_W | Queue being set up |
| qset_num | output | NUM_W | Queue size |
| qset_align | output | 32 | Queue alignment |
| qset_base | output | BASE_W | Queue base address |
| notify_valid | output | 1 | Doorbell strobe |
| notify_idx | output | QI_W | Doorbell queue index |
| dev_reset | output | 1 | Device reset pulse |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several rules on every cycle. The interrupt line must equal "interrupt status nonzero". A dev_reset pulse must leave status, interrupt status and queue select at zero. Strobes must never follow an access made with no backend or with the wrong width below 0x100. A notify strobe must trace back to a doorbell write, config accesses must stay in the upper half of the window, and no queue size may exceed QMAX. Only the bench scenarios can show the data paths. These include the trailing-zero page shift and the PFN scaling in both directions, the feature-select gating, the out-of-range select and notify values, and the partial interrupt acknowledges. They also cover the identification answers with the backend absent and register contents surviving a backend attach.

// File: rtl/pvio_pkg.sv
package pvio_pkg;

  localparam logic [8:0] OFS_MAGIC   = 9'h000;
  localparam logic [8:0] OFS_VERSION = 9'h004;
  localparam logic [8:0] OFS_DEVID   = 9'h008;
  localparam logic [8:0] OFS_VENDOR  = 9'h00C;
  localparam logic [8:0] OFS_HFEAT   = 9'h010;
  localparam logic [8:0] OFS_HSEL    = 9'h014;
  localparam logic [8:0] OFS_GFEAT   = 9'h020;
  localparam logic [8:0] OFS_GSEL    = 9'h024;
  localparam logic [8:0] OFS_PGSIZE  = 9'h028;
  localparam logic [8:0] OFS_QSEL    = 9'h030;
  localparam logic [8:0] OFS_QMAX    = 9'h034;
  localparam logic [8:0] OFS_QNUM    = 9'h038;
  localparam logic [8:0] OFS_QALIGN  = 9'h03C;
  localparam logic [8:0] OFS_QPFN    = 9'h040;
  localparam logic [8:0] OFS_NOTIFY  = 9'h050;
  localparam logic [8:0] OFS_ISR     = 9'h060;
  localparam logic [8:0] OFS_ACK     = 9'h064;
  localparam logic [8:0] OFS_STATUS  = 9'h070;

  localparam logic [31:0] MAGIC_VAL   = 32'h7472_6976;
  localparam logic [31:0] VERSION_VAL = 32'd1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [4:0] {
    RG_NONE, RG_MAGIC, RG_VERSION, RG_DEVID, RG_VENDOR,
    RG_HFEAT, RG_HSEL, RG_GFEAT, RG_GSEL, RG_PGSIZE,
    RG_QSEL, RG_QMAX, RG_QNUM, RG_QALIGN, RG_QPFN,
    RG_NOTIFY, RG_ISR, RG_ACK, RG_STATUS
  } reg_e;

  // index of the lowest set bit, 0 when no bit is set
  function automatic logic [4:0] low_bit_index(input logic [31:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/pvio_decode.sv
module pvio_decode
  import pvio_pkg::*;
(
  input  logic [8:0] addr,
  input  logic [1:0] size,
  output reg_e       sel,
  output logic       cfg_hit,
  output logic       word_ok,
  output logic       cfg_size_ok
);

  assign cfg_hit     = addr[8];
  assign word_ok     = (size == SZ_WORD);
  assign cfg_size_ok = (size != SZ_BAD);

  always_comb begin
    sel = RG_NONE;
    if (!addr[8]) begin
      case (addr)
        OFS_MAGIC:   sel = RG_MAGIC;
        OFS_VERSION: sel = RG_VERSION;
        OFS_DEVID:   sel = RG_DEVID;
        OFS_VENDOR:  sel = RG_VENDOR;
        OFS_HFEAT:   sel = RG_HFEAT;
        OFS_HSEL:    sel = RG_HSEL;
        OFS_GFEAT:   sel = RG_GFEAT;
        OFS_GSEL:    sel = RG_GSEL;
        OFS_PGSIZE:  sel = RG_PGSIZE;
        OFS_QSEL:    sel = RG_QSEL;
        OFS_QMAX:    sel = RG_QMAX;
        OFS_QNUM:    sel = RG_QNUM;
        OFS_QALIGN:  sel = RG_QALIGN;
        OFS_QPFN:    sel = RG_QPFN;
        OFS_NOTIFY:  sel = RG_NOTIFY;
        OFS_ISR:     sel = RG_ISR;
        OFS_ACK:     sel = RG_ACK;
        OFS_STATUS:  sel = RG_STATUS;
        default:     sel = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/pvio_queue_bank.sv
module pvio_queue_bank #(
  parameter int NQ     = 8,
  parameter int QMAX   = 1024,
  parameter int BASE_W = 64,
  localparam int QI_W  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int NUM_W = $clog2(QMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_base,
  input  logic [QI_W-1:0]   idx,
  input  logic              we_num,
  input  logic [NUM_W-1:0]  num_in,
  input  logic              we_align,
  input  logic [31:0]       align_in,
  input  logic              we_base,
  input  logic [BASE_W-1:0] base_in,
  output logic [NUM_W-1:0]  num_out,
  output logic [31:0]       align_out,
  output logic [BASE_W-1:0] base_out
);

  logic [NUM_W-1:0]  num_r   [NQ];
  logic [31:0]       align_r [NQ];
  logic [BASE_W-1:0] base_r  [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    logic hit;
    assign hit = (idx == QI_W'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        num_r[q]   <= '0;
        align_r[q] <= '0;
      end else begin
        if (we_num && hit)   num_r[q]   <= num_in;
        if (we_align && hit) align_r[q] <= align_in;
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr_base)     base_r[q] <= '0;
      else if (we_base && hit) base_r[q] <= base_in;
    end

    // R12: no queue ever holds a size above the limit
    a_r12_size_bound: assert property (@(posedge clk) disable iff (rst)
      num_r[q] <= NUM_W'(QMAX));
  end

  assign num_out   = num_r[idx];
  assign align_out = align_r[idx];
  assign base_out  = base_r[idx];

endmodule

// File: rtl/pvio_irq.sv
module pvio_irq #(
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ISR_W-1:0] set_mask,
  input  logic             ack_we,
  input  logic [ISR_W-1:0] ack_mask,
  output logic [ISR_W-1:0] isr,
  output logic             irq
);

  logic [ISR_W-1:0] isr_next;

  always_comb begin
    isr_next = isr;
    if (ack_we) isr_next = isr_next & ~ack_mask;
    isr_next = isr_next | set_mask;
    if (clr) isr_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
      irq <= 1'b0;
    end else begin
      isr <= isr_next;
      irq <= (isr_next != '0);
    end
  end

  // R10: level output tracks the cause register
  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (isr != '0));

endmodule

// File: rtl/pvio_regfile.sv
module pvio_regfile
  import pvio_pkg::*;
#(
  parameter int          NQ        = 8,
  parameter int          QMAX      = 1024,
  parameter int          ISR_W     = 8,
  parameter int          BASE_W    = 64,
  parameter logic [31:0] VENDOR_ID = 32'h5056_494F,
  localparam int         QI_W      = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int         NUM_W     = $clog2(QMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [8:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              backend_present,
  input  logic [31:0]       device_id,
  input  logic [31:0]       host_features,
  input  logic [ISR_W-1:0]  isr_set,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [7:0]        cfg_addr,
  output logic [1:0]        cfg_size,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  output logic [31:0]       guest_features,
  output logic              qset_valid,
  output logic [QI_W-1:0]   qset_idx,
  output logic [NUM_W-1:0]  qset_num,
  output logic [31:0]       qset_align,
  output logic [BASE_W-1:0] qset_base,
  output logic              notify_valid,
  output logic [QI_W-1:0]   notify_idx,
  output logic              dev_reset,
  output logic              irq
);

  reg_e sel;
  logic cfg_hit, word_ok, cfg_size_ok;

  pvio_decode u_dec (
    .addr        (req_addr),
    .size        (req_size),
    .sel         (sel),
    .cfg_hit     (cfg_hit),
    .word_ok     (word_ok),
    .cfg_size_ok (cfg_size_ok)
  );

  logic        rd_acc, wr_reg;
  logic [31:0] host_sel, guest_sel;
  logic [4:0]  page_shift;
  logic [7:0]  status_q;
  logic [QI_W-1:0] qsel;
  logic [ISR_W-1:0] isr;

  assign req_ready = 1'b1;
  assign rd_acc    = req_valid && !req_write;
  assign wr_reg    = req_valid && req_write && backend_present && word_ok && !cfg_hit;

  // config window pass-through
  assign cfg_valid = req_valid && backend_present && cfg_hit && cfg_size_ok;
  assign cfg_write = req_write;
  assign cfg_addr  = req_addr[7:0];
  assign cfg_size  = req_size;
  assign cfg_wdata = req_wdata;

  // write decode
  logic wsel_pfn, wsel_status, dev_rst_now;
  logic we_num, we_align, we_base, ack_we;
  logic [BASE_W-1:0] base_wr;

  assign wsel_pfn    = wr_reg && (sel == RG_QPFN);
  assign wsel_status = wr_reg && (sel == RG_STATUS);
  assign dev_rst_now = (wsel_pfn && (req_wdata == 32'd0)) ||
                       (wsel_status && (req_wdata[7:0] == 8'd0));
  assign we_num      = wr_reg && (sel == RG_QNUM) && (req_wdata <= 32'(QMAX));
  assign we_align    = wr_reg && (sel == RG_QALIGN);
  assign we_base     = wsel_pfn && (req_wdata != 32'd0);
  assign ack_we      = wr_reg && (sel == RG_ACK);
  assign base_wr     = BASE_W'(req_wdata) << page_shift;

  logic [NUM_W-1:0]  cur_num;
  logic [31:0]       cur_align;
  logic [BASE_W-1:0] cur_base;

  pvio_queue_bank #(.NQ(NQ), .QMAX(QMAX), .BASE_W(BASE_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr_base  (dev_rst_now),
    .idx       (qsel),
    .we_num    (we_num),
    .num_in    (req_wdata[NUM_W-1:0]),
    .we_align  (we_align),
    .align_in  (req_wdata),
    .we_base   (we_base),
    .base_in   (base_wr),
    .num_out   (cur_num),
    .align_out (cur_align),
    .base_out  (cur_base)
  );

  pvio_irq #(.ISR_W(ISR_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .clr      (dev_rst_now),
    .set_mask (isr_set),
    .ack_we   (ack_we),
    .ack_mask (req_wdata[ISR_W-1:0]),
    .isr      (isr),
    .irq      (irq)
  );

  // transport control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      host_sel   <= '0;
      guest_sel  <= '0;
      page_shift <= '0;
    end else if (wr_reg) begin
      case (sel)
        RG_HSEL:   host_sel   <= req_wdata;
        RG_GSEL:   guest_sel  <= req_wdata;
        RG_PGSIZE: page_shift <= low_bit_index(req_wdata);
        default: ;
      endcase
    end
  end

  // device state, cleared also by a device reset
  always_ff @(posedge clk) begin
    if (rst || dev_rst_now) begin
      guest_features <= '0;
      status_q       <= '0;
      qsel           <= '0;
    end else if (wr_reg) begin
      case (sel)
        RG_GFEAT:  if (guest_sel == 32'd0) guest_features <= req_wdata;
        RG_STATUS: status_q <= req_wdata[7:0];
        RG_QSEL:   if (req_wdata < 32'(NQ)) qsel <= req_wdata[QI_W-1:0];
        default: ;
      endcase
    end
  end

  // backend strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      qset_valid   <= 1'b0;
      qset_idx     <= '0;
      qset_num     <= '0;
      qset_align   <= '0;
      qset_base    <= '0;
      notify_valid <= 1'b0;
      notify_idx   <= '0;
      dev_reset    <= 1'b0;
    end else begin
      qset_valid   <= we_num || we_align || we_base;
      qset_idx     <= qsel;
      qset_num     <= we_num   ? req_wdata[NUM_W-1:0] : cur_num;
      qset_align   <= we_align ? req_wdata : cur_align;
      qset_base    <= we_base  ? base_wr : cur_base;
      notify_valid <= wr_reg && (sel == RG_NOTIFY) && (req_wdata < 32'(NQ));
      notify_idx   <= req_wdata[QI_W-1:0];
      dev_reset    <= dev_rst_now;
    end
  end

  // read path
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (cfg_hit) begin
      if (backend_present && cfg_size_ok) rd_val = cfg_rdata;
    end else if (word_ok) begin
      case (sel)
        RG_MAGIC:   rd_val = MAGIC_VAL;
        RG_VERSION: rd_val = VERSION_VAL;
        RG_VENDOR:  rd_val = VENDOR_ID;
        default: begin
          if (backend_present) begin
            case (sel)
              RG_DEVID:  rd_val = device_id;
              RG_HFEAT:  rd_val = (host_sel == 32'd0) ? host_features : 32'd0;
              RG_QMAX:   rd_val = 32'(QMAX);
              RG_QPFN:   rd_val = 32'(cur_base >> page_shift);
              RG_ISR:    rd_val = 32'(isr);
              RG_STATUS: rd_val = {24'd0, status_q};
              default:   rd_val = '0;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      rsp_rdata <= rd_acc ? rd_val : 32'd0;
    end
  end

  // R2: with no backend attached nothing reaches the backend
  a_r2_no_backend_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !backend_present) |=> (!notify_valid && !qset_valid && !dev_reset));

  // R3: narrow accesses below the config window have no effect
  a_r3_narrow_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_addr[8] && (req_size != SZ_WORD)) |=>
      (!notify_valid && !qset_valid && !dev_reset));

  // R4: config accesses only for the upper half with a backend
  a_r4_cfg_window: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (req_addr[8] && backend_present && req_valid));

  // R8: a device reset leaves the device state cleared
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    dev_reset |-> (status_q == 8'd0 && isr == '0 && qsel == '0 && guest_features == 32'd0));

  // R9: a doorbell strobe follows a doorbell write
  a_r9_notify_source: assert property (@(posedge clk) disable iff (rst)
    notify_valid |-> $past(req_valid && req_write && req_addr == OFS_NOTIFY && backend_present));

endmodule

// File: tb/pvio_regfile_test.sv
`timescale 1ns/1ps
module pvio_regfile_test;

  localparam int NQ = 8, QMAX = 1024, ISR_W = 8, BASE_W = 64;
  localparam logic [31:0] VID = 32'h5056_494F;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req_valid, req_write, req_ready, rsp_valid, backend_present;
  logic [8:0] req_addr;
  logic [1:0] req_size;
  logic [31:0] req_wdata, rsp_rdata, device_id, host_features, cfg_rdata;
  logic [ISR_W-1:0] isr_set;
  logic cfg_valid, cfg_write, qset_valid, notify_valid, dev_reset, irq;
  logic [7:0] cfg_addr;
  logic [1:0] cfg_size;
  logic [31:0] cfg_wdata, guest_features, qset_align;
  logic [2:0] qset_idx, notify_idx;
  logic [10:0] qset_num;
  logic [BASE_W-1:0] qset_base;

  pvio_regfile #(.NQ(NQ), .QMAX(QMAX), .ISR_W(ISR_W), .BASE_W(BASE_W), .VENDOR_ID(VID)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .backend_present(backend_present), .device_id(device_id),
    .host_features(host_features), .isr_set(isr_set),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .guest_features(guest_features), .qset_valid(qset_valid),
    .qset_idx(qset_idx), .qset_num(qset_num), .qset_align(qset_align),
    .qset_base(qset_base), .notify_valid(notify_valid),
    .notify_idx(notify_idx), .dev_reset(dev_reset), .irq(irq)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read responses against the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("unexpected response", 64'd1, 64'd0);
      else chk(tag_q.pop_front(), {32'd0, rsp_rdata}, {32'd0, exp_q.pop_front()});
    end
  end

  // called at a negedge; returns at the negedge after the access
  task automatic acc(input logic w, input logic [8:0] a, input logic [1:0] s, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    acc(1'b1, a, 2'd2, d);
  endtask

  task automatic rd(input logic [8:0] a, input logic [1:0] s, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc(1'b0, a, s, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
    backend_present = 0; device_id = 32'h12; host_features = 32'hDEAD_BEEF;
    isr_set = 0; cfg_rdata = 32'hCAFE_0011;
    repeat (3) @(negedge clk);
    rst = 0;
    // R14 reset state
    chk("R14 irq", {63'd0, irq}, 0);
    chk("R14 strobes", {61'd0, dev_reset, notify_valid, qset_valid}, 0);
    chk("R14 rsp_valid", {63'd0, rsp_valid}, 0);
    chk("R14 guest_features", {32'd0, guest_features}, 0);

    // R1 and R2 with no backend
    rd(9'h000, 2'd2, 32'h7472_6976, "R1 magic absent");
    rd(9'h004, 2'd2, 32'd1, "R1 version absent");
    rd(9'h00C, 2'd2, VID, "R1 vendor absent");
    rd(9'h008, 2'd2, 32'd0, "R2 devid absent");
    rd(9'h010, 2'd2, 32'd0, "R2 hfeat absent");
    wr(9'h070, 32'h0F);
    wr(9'h020, 32'h77);
    chk("R2 gfeat write dropped", {32'd0, guest_features}, 0);
    wr(9'h050, 32'd2);
    chk("R2 notify dropped", {63'd0, notify_valid}, 0);
    req_valid = 1; req_write = 0; req_addr = 9'h104; req_size = 2'd2;
    #1 chk("R2 no cfg access absent", {63'd0, cfg_valid}, 0);
    exp_q.push_back(32'd0); tag_q.push_back("R2 cfg read absent");
    @(negedge clk); req_valid = 0;
    backend_present = 1;
    rd(9'h070, 2'd2, 32'd0, "R2 status untouched");
    rd(9'h008, 2'd2, 32'h12, "R1 devid present");
    rd(9'h000, 2'd2, 32'h7472_6976, "R1 magic present");

    // R3 narrow accesses
    rd(9'h000, 2'd1, 32'd0, "R3 half read magic");
    acc(1'b1, 9'h070, 2'd0, 32'h05);
    rd(9'h070, 2'd2, 32'd0, "R3 byte write status");

    // R11 status
    wr(9'h070, 32'h1A3);
    rd(9'h070, 2'd2, 32'hA3, "R11 status low byte");

    // R5 host feature select
    rd(9'h010, 2'd2, 32'hDEAD_BEEF, "R5 hfeat sel0");
    wr(9'h014, 32'd1);
    rd(9'h010, 2'd2, 32'd0, "R5 hfeat sel1");
    wr(9'h014, 32'd0);
    rd(9'h010, 2'd2, 32'hDEAD_BEEF, "R5 hfeat sel back");

    // R6 guest feature select
    wr(9'h020, 32'h55);
    chk("R6 gfeat sel0", {32'd0, guest_features}, 64'h55);
    wr(9'h024, 32'd1);
    wr(9'h020, 32'h99);
    chk("R6 gfeat sel1 ignored", {32'd0, guest_features}, 64'h55);
    wr(9'h024, 32'd0);

    // R13 read-only / write-only
    rd(9'h034, 2'd2, 32'd1024, "R13 qmax");
    rd(9'h038, 2'd2, 32'd0, "R13 qnum write-only");
    rd(9'h024, 2'd2, 32'd0, "R13 gsel write-only");
    rd(9'h0F0, 2'd2, 32'd0, "R13 unmapped");

    // R12 queue setup
    wr(9'h030, 32'd3);
    wr(9'h038, 32'd256);
    chk("R12 qset strobe", {63'd0, qset_valid}, 1);
    chk("R12 qset idx", {61'd0, qset_idx}, 3);
    chk("R12 qset num", {53'd0, qset_num}, 256);
    wr(9'h038, 32'd2000);
    chk("R12 oversize no strobe", {63'd0, qset_valid}, 0);
    wr(9'h03C, 32'd4096);
    chk("R12 size kept", {53'd0, qset_num}, 256);
    chk("R12 align", {32'd0, qset_align}, 4096);

    // R7 page shift and frame number
    wr(9'h028, 32'd4096);
    wr(9'h040, 32'h12345);
    chk("R7 base scaled", qset_base, 64'h1234_5000);
    rd(9'h040, 2'd2, 32'h12345, "R7 pfn readback");
    wr(9'h028, 32'd0);
    rd(9'h040, 2'd2, 32'h1234_5000, "R7 shift zero");
    wr(9'h028, 32'h30);
    rd(9'h040, 2'd2, 32'h0123_4500, "R7 shift four");

    // R9 select and doorbell range
    wr(9'h030, 32'd9);
    wr(9'h03C, 32'd64);
    chk("R9 qsel out of range", {61'd0, qset_idx}, 3);
    wr(9'h050, 32'd9);
    chk("R9 notify out of range", {63'd0, notify_valid}, 0);
    wr(9'h050, 32'd5);
    chk("R9 notify strobe", {63'd0, notify_valid}, 1);
    chk("R9 notify idx", {61'd0, notify_idx}, 5);
    @(negedge clk);
    chk("R9 notify one cycle", {63'd0, notify_valid}, 0);

    // R10 interrupts
    isr_set = 8'h05; @(negedge clk); isr_set = 0;
    chk("R10 irq high", {63'd0, irq}, 1);
    rd(9'h060, 2'd2, 32'h05, "R10 isr read");
    wr(9'h064, 32'h01);
    chk("R10 irq partial ack", {63'd0, irq}, 1);
    rd(9'h060, 2'd2, 32'h04, "R10 isr after ack");
    wr(9'h064, 32'h04);
    chk("R10 irq low", {63'd0, irq}, 0);

    // R8 device reset by zero frame number
    isr_set = 8'h02; @(negedge clk); isr_set = 0;
    wr(9'h040, 32'd0);
    chk("R8 dev_reset pulse", {63'd0, dev_reset}, 1);
    chk("R8 irq cleared", {63'd0, irq}, 0);
    chk("R8 gfeat cleared", {32'd0, guest_features}, 0);
    rd(9'h070, 2'd2, 32'd0, "R8 status cleared");
    wr(9'h030, 32'd3);
    rd(9'h040, 2'd2, 32'd0, "R8 base cleared");
    wr(9'h014, 32'd1);
    wr(9'h070, 32'h100);
    chk("R8 status zero reset", {63'd0, dev_reset}, 1);
    rd(9'h010, 2'd2, 32'd0, "R8 hsel kept");
    wr(9'h014, 32'd0);

    // R4 config window
    req_valid = 1; req_write = 0; req_addr = 9'h104; req_size = 2'd1;
    #1;
    chk("R4 cfg valid", {63'd0, cfg_valid}, 1);
    chk("R4 cfg addr", {56'd0, cfg_addr}, 64'h04);
    chk("R4 cfg size", {62'd0, cfg_size}, 1);
    exp_q.push_back(32'hCAFE_0011); tag_q.push_back("R4 cfg read data");
    @(negedge clk); req_valid = 0;
    req_valid = 1; req_write = 1; req_addr = 9'h1FC; req_size = 2'd2; req_wdata = 32'hA5A5_0F0F;
    #1;
    chk("R4 cfg write", {63'd0, cfg_write}, 1);
    chk("R4 cfg write addr", {56'd0, cfg_addr}, 64'hFC);
    chk("R4 cfg wdata", {32'd0, cfg_wdata}, 64'hA5A5_0F0F);
    @(negedge clk); req_valid = 0; req_write = 0;

    repeat (2) @(negedge clk);
    chk("all responses seen", {32'd0, 32'(exp_q.size())}, 0);
    finish_run();
  end

endmodule